// File: doc/BRIEF.md
# Quasi-Cyclic LDPC Variable-Node Update Lane

This block is the variable-node datapath of a layered quasi-cyclic LDPC decoder. Each cycle it can accept one block of Z posterior log-likelihood ratios taken from the posterior store, along with the circulant shift of the base-matrix entry being processed and the check messages that this entry produced on its previous visit. It rotates the block into check-node order and removes the old check message to form the extrinsic values. Those values are then clipped to the narrower message width and sent to the check-node units.

Two cycles after a block enters, the check-node units return fresh messages for it. The lane adds them to the extrinsic values of that same block, which it has carried through its two internal stages. It rotates the sums back into storage order and presents them as write-back data together with one hard decision per lane. A shift code of all ones marks an all-zero circulant. In that case the block goes through untouched, no messages are issued and no write-back is requested. The posterior store, the check-node units and the schedule sequencing are outside this block.

Top module: `vnu_lane`

## Requirements
- R1: While reset is held and in the first cycle after it, `v2c_valid`, `out_valid`, `out_wr_en`, `out_llr` and `out_hard` are all zero.
- R2: The forward rotation is left-cyclic by the shift s (0 <= s < Z). Message lane i is derived from input lane (i + s) mod Z of `in_llr`. Lane i occupies bits [i*W +: W] of every bus.
- R3: Extrinsic lane i equals the rotated posterior minus `in_old_c2v` lane i, in two's complement, saturated to [-64, 63]. `v2c_data` lane i is that extrinsic value saturated to [-16, 15].
- R4: A block accepted with `in_valid` high and a shift other than all ones raises `v2c_valid` on the following cycle, with its `v2c_data`.
- R5: `new_c2v` is taken in the second cycle after the block's input cycle. The updated posterior is that block's own extrinsic value plus `new_c2v`, saturated to [-64, 63].
- R6: The reverse rotation is left-cyclic by (Z - s) mod Z, so `out_llr` lane j is the updated posterior that originated from input lane j.
- R7: `out_valid` rises in the third cycle after the input cycle, and only for accepted blocks.
- R8: `out_hard` bit j is 1 exactly when `out_llr` lane j is negative.
- R9: With shift 6'b111111, `v2c_valid` stays low, `out_llr` equals `in_llr` unchanged, `new_c2v` has no effect, `out_valid` is high and `out_wr_en` is low. For any other shift of a valid block, `out_wr_en` is high together with `out_valid`.
- R10: A new block can enter on every cycle. Each block's result depends only on its own inputs and on the `new_c2v` presented in its own slot.
- R11: A cycle with `in_valid` low produces no `v2c_valid`, `out_valid` or `out_wr_en` in the matching later cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A block is presented this cycle |
| in_shift | input | SHIFT_W (6) | Circulant shift; all ones marks a zero circulant |
| in_llr | input | Z*LLR_W (294) | Posterior LLRs in storage order |
| in_old_c2v | input | Z*MSG_W (210) | Previous check messages, check order |
| v2c_valid | output | 1 | Variable-to-check messages valid |
| v2c_data | output | Z*MSG_W (210) | Saturated variable-to-check messages |
| new_c2v | input | Z*MSG_W (210) | Fresh check messages for the block in stage two |
| out_valid | output | 1 | Write-back slot valid |
| out_wr_en | output | 1 | Write-back requested |
| out_llr | output | Z*LLR_W (294) | Updated posteriors in storage order |
| out_hard | output | Z | Hard decisions, 1 for a negative posterior |

## Verification
The first pattern sweeps the shift through every value from 0 to Z-1 on back-to-back random blocks. A wrong rotation index, or a reverse rotation that is not the true inverse, then shows up at a known lane. The second pattern uses blocks pinned at the extremes: largest posterior with the most negative old message, and the mirror case. This separates saturation of the subtraction, the addition and the message clip from plain wrap-around. The third pattern interleaves zero-circulant codes with normal ones while `new_c2v` keeps changing, which exposes any leak of the bypass into write-back or message issue. The last pattern mixes idle gaps with a continuous stream, which reveals a pipeline that pairs a fresh message with the extrinsic value of a neighbouring block.

// File: rtl/vnu_pkg.sv
package vnu_pkg;

  // Clamp an integer into the signed range of a w-bit two's complement word.
  function automatic int vnu_sat(input int v, input int w);
    int hi;
    int lo;
    hi = (1 << (w - 1)) - 1;
    lo = -(1 << (w - 1));
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  // Source lane for a left-cyclic rotation by amt over z lanes.
  function automatic int vnu_src_lane(input int lane, input int amt, input int z);
    return (lane + amt) % z;
  endfunction

endpackage

// File: rtl/vnu_rotator.sv
module vnu_rotator #(
  parameter int Z       = 42,
  parameter int W       = 7,
  parameter int SHIFT_W = 6,
  parameter bit REVERSE = 1'b0
) (
  input  logic [Z*W-1:0]     din,
  input  logic [SHIFT_W-1:0] shift,
  output logic [Z*W-1:0]     dout
);
  import vnu_pkg::*;

  int base_amt;
  int amt;

  // An all-ones code means no rotation at all.
  always_comb begin
    if (&shift) base_amt = 0;
    else        base_amt = int'(shift) % Z;
  end

  generate
    if (REVERSE) begin : g_rev
      always_comb amt = (Z - base_amt) % Z;
    end else begin : g_fwd
      always_comb amt = base_amt;
    end
  endgenerate

  always_comb begin
    for (int i = 0; i < Z; i++) begin
      dout[i*W +: W] = din[vnu_src_lane(i, amt, Z)*W +: W];
    end
  end

endmodule

// File: rtl/vnu_ext_unit.sv
module vnu_ext_unit #(
  parameter int Z     = 42,
  parameter int LLR_W = 7,
  parameter int MSG_W = 5
) (
  input  logic [Z*LLR_W-1:0] rot,
  input  logic [Z*MSG_W-1:0] old_c2v,
  input  logic               bypass,
  output logic [Z*LLR_W-1:0] ext,
  output logic [Z*MSG_W-1:0] v2c
);
  import vnu_pkg::*;

  always_comb begin
    int a;
    int b;
    int e;
    for (int i = 0; i < Z; i++) begin
      a = int'($signed(rot[i*LLR_W +: LLR_W]));
      b = int'($signed(old_c2v[i*MSG_W +: MSG_W]));
      e = bypass ? a : vnu_sat(a - b, LLR_W);
      ext[i*LLR_W +: LLR_W] = LLR_W'(e);
      v2c[i*MSG_W +: MSG_W] = MSG_W'(vnu_sat(e, MSG_W));
    end
  end

endmodule

// File: rtl/vnu_post_unit.sv
module vnu_post_unit #(
  parameter int Z     = 42,
  parameter int LLR_W = 7,
  parameter int MSG_W = 5
) (
  input  logic [Z*LLR_W-1:0] ext,
  input  logic [Z*MSG_W-1:0] c2v,
  input  logic               bypass,
  output logic [Z*LLR_W-1:0] post
);
  import vnu_pkg::*;

  always_comb begin
    int a;
    int b;
    int p;
    for (int i = 0; i < Z; i++) begin
      a = int'($signed(ext[i*LLR_W +: LLR_W]));
      b = int'($signed(c2v[i*MSG_W +: MSG_W]));
      p = bypass ? a : vnu_sat(a + b, LLR_W);
      post[i*LLR_W +: LLR_W] = LLR_W'(p);
    end
  end

endmodule

// File: rtl/vnu_lane.sv
module vnu_lane #(
  parameter int Z       = 42,
  parameter int LLR_W   = 7,
  parameter int MSG_W   = 5,
  parameter int SHIFT_W = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [SHIFT_W-1:0]   in_shift,
  input  logic [Z*LLR_W-1:0]   in_llr,
  input  logic [Z*MSG_W-1:0]   in_old_c2v,
  output logic                 v2c_valid,
  output logic [Z*MSG_W-1:0]   v2c_data,
  input  logic [Z*MSG_W-1:0]   new_c2v,
  output logic                 out_valid,
  output logic                 out_wr_en,
  output logic [Z*LLR_W-1:0]   out_llr,
  output logic [Z-1:0]         out_hard
);

  localparam int LLR_BUS = Z * LLR_W;
  localparam int MSG_BUS = Z * MSG_W;

  // Stage-one inputs
  logic               in_zero;
  logic [LLR_BUS-1:0] rot_w;
  logic [LLR_BUS-1:0] ext_w;
  logic [MSG_BUS-1:0] v2c_w;

  // Stage registers: the extrinsic value rides along with its block.
  logic               s1_valid, s1_zero;
  logic [SHIFT_W-1:0] s1_shift;
  logic [LLR_BUS-1:0] s1_ext;
  logic [MSG_BUS-1:0] s1_v2c;

  logic               s2_valid, s2_zero;
  logic [SHIFT_W-1:0] s2_shift;
  logic [LLR_BUS-1:0] s2_ext;

  // Write-back side
  logic [LLR_BUS-1:0] post_w;
  logic [LLR_BUS-1:0] back_w;
  logic [Z-1:0]       hard_w;

  // Named events for the checker
  logic               mid_valid;

  assign in_zero = &in_shift;

  vnu_rotator #(.Z(Z), .W(LLR_W), .SHIFT_W(SHIFT_W), .REVERSE(1'b0)) u_fwd (
    .din   (in_llr),
    .shift (in_shift),
    .dout  (rot_w)
  );

  vnu_ext_unit #(.Z(Z), .LLR_W(LLR_W), .MSG_W(MSG_W)) u_ext (
    .rot     (rot_w),
    .old_c2v (in_old_c2v),
    .bypass  (in_zero),
    .ext     (ext_w),
    .v2c     (v2c_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_zero  <= 1'b0;
      s1_shift <= '0;
      s1_ext   <= '0;
      s1_v2c   <= '0;
    end else begin
      s1_valid <= in_valid;
      s1_zero  <= in_zero;
      s1_shift <= in_shift;
      s1_ext   <= ext_w;
      s1_v2c   <= v2c_w;
    end
  end

  assign v2c_valid = s1_valid & ~s1_zero;
  assign v2c_data  = s1_v2c;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s2_valid <= 1'b0;
      s2_zero  <= 1'b0;
      s2_shift <= '0;
      s2_ext   <= '0;
    end else begin
      s2_valid <= s1_valid;
      s2_zero  <= s1_zero;
      s2_shift <= s1_shift;
      s2_ext   <= s1_ext;
    end
  end

  assign mid_valid = s2_valid;

  vnu_post_unit #(.Z(Z), .LLR_W(LLR_W), .MSG_W(MSG_W)) u_post (
    .ext    (s2_ext),
    .c2v    (new_c2v),
    .bypass (s2_zero),
    .post   (post_w)
  );

  vnu_rotator #(.Z(Z), .W(LLR_W), .SHIFT_W(SHIFT_W), .REVERSE(1'b1)) u_rev (
    .din   (post_w),
    .shift (s2_shift),
    .dout  (back_w)
  );

  generate
    for (genvar g = 0; g < Z; g++) begin : g_hard
      assign hard_w[g] = back_w[g*LLR_W + LLR_W - 1];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_wr_en <= 1'b0;
      out_llr   <= '0;
      out_hard  <= '0;
    end else begin
      out_valid <= s2_valid;
      out_wr_en <= s2_valid & ~s2_zero;
      out_llr   <= back_w;
      out_hard  <= hard_w;
    end
  end

endmodule

// File: rtl/vnu_lane_checker.sv
module vnu_lane_checker #(
  parameter int Z       = 42,
  parameter int LLR_W   = 7,
  parameter int SHIFT_W = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic [SHIFT_W-1:0] in_shift,
  input logic               v2c_valid,
  input logic               mid_valid,
  input logic               out_valid,
  input logic               out_wr_en,
  input logic [Z*LLR_W-1:0] out_llr,
  input logic [Z-1:0]       out_hard
);

  logic [Z-1:0] sgn;
  generate
    for (genvar g = 0; g < Z; g++) begin : g_sgn
      assign sgn[g] = out_llr[g*LLR_W + LLR_W - 1];
    end
  endgenerate

  a_r4_v2c_after_block: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !(&in_shift)) |=> v2c_valid);

  a_r9_zero_no_v2c: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (&in_shift)) |=> !v2c_valid);

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !v2c_valid);

  a_r10_mid_after_v2c: assert property (@(posedge clk) disable iff (!rst_n)
    v2c_valid |=> mid_valid);

  a_r7_out_after_mid: assert property (@(posedge clk) disable iff (!rst_n)
    mid_valid |=> out_valid);

  a_r7_no_out_without_mid: assert property (@(posedge clk) disable iff (!rst_n)
    !mid_valid |=> !out_valid);

  a_r9_write_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_wr_en |-> out_valid);

  a_r8_hard_is_sign: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_hard == sgn));

endmodule

bind vnu_lane vnu_lane_checker #(.Z(Z), .LLR_W(LLR_W), .SHIFT_W(SHIFT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_shift  (in_shift),
  .v2c_valid (v2c_valid),
  .mid_valid (mid_valid),
  .out_valid (out_valid),
  .out_wr_en (out_wr_en),
  .out_llr   (out_llr),
  .out_hard  (out_hard)
);

// File: tb/tb_vnu_lane.sv
`timescale 1ns/1ps
module tb_vnu_lane;
  localparam int Z = 42;
  localparam int LW = 7;
  localparam int MW = 5;
  localparam int SW = 6;
  localparam int NCYC = 300;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [SW-1:0] in_shift = '0;
  logic [Z*LW-1:0] in_llr = '0;
  logic [Z*MW-1:0] in_old_c2v = '0;
  logic [Z*MW-1:0] new_c2v = '0;
  logic v2c_valid, out_valid, out_wr_en;
  logic [Z*MW-1:0] v2c_data;
  logic [Z*LW-1:0] out_llr;
  logic [Z-1:0] out_hard;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [Z*LW-1:0] st_llr [NCYC];
  logic [Z*MW-1:0] st_old [NCYC];
  logic [Z*MW-1:0] st_c2v [NCYC];
  logic [SW-1:0]   st_sh  [NCYC];
  logic            st_val [NCYC];

  always #2.5 clk = ~clk;

  vnu_lane #(.Z(Z), .LLR_W(LW), .MSG_W(MW), .SHIFT_W(SW)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_shift(in_shift),
    .in_llr(in_llr), .in_old_c2v(in_old_c2v), .v2c_valid(v2c_valid),
    .v2c_data(v2c_data), .new_c2v(new_c2v), .out_valid(out_valid),
    .out_wr_en(out_wr_en), .out_llr(out_llr), .out_hard(out_hard)
  );

  function automatic int clip(int v, int lo, int hi);
    return (v > hi) ? hi : ((v < lo) ? lo : v);
  endfunction

  function automatic int lane_l(int n, int i);
    return int'($signed(st_llr[n][i*LW +: LW]));
  endfunction

  function automatic int lane_m(logic [Z*MW-1:0] v, int i);
    return int'($signed(v[i*MW +: MW]));
  endfunction

  // Extrinsic value of block n at check-order lane i.
  function automatic int model_ext(int n, int i);
    int s;
    s = int'(st_sh[n]);
    if (s == 63) return lane_l(n, i);
    return clip(lane_l(n, (i + s) % Z) - lane_m(st_old[n], i), -64, 63);
  endfunction

  task automatic check(string req, logic [Z*LW-1:0] act, logic [Z*LW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Compare everything visible after edge k.
  task automatic check_cycle(int k);
    logic [Z*MW-1:0] ev;
    logic [Z*LW-1:0] eo;
    logic [Z-1:0] eh;
    bit vv, ov, ow;
    int m, s, src, p;
    vv = st_val[k] && (st_sh[k] != 6'h3f);
    check(vv ? "R4 v2c_valid" : "R9 R11 v2c_valid", {293'b0, v2c_valid}, {293'b0, vv});
    if (vv) begin
      for (int i = 0; i < Z; i++) ev[i*MW +: MW] = MW'(clip(model_ext(k, i), -16, 15));
      check("R2 R3 v2c_data", {84'b0, v2c_data}, {84'b0, ev});
    end
    m = k - 2;
    ov = (m >= 0) && st_val[m];
    ow = ov && (st_sh[m] != 6'h3f);
    check("R7 R11 out_valid", {293'b0, out_valid}, {293'b0, ov});
    check("R9 out_wr_en", {293'b0, out_wr_en}, {293'b0, ow});
    if (ov) begin
      s = int'(st_sh[m]);
      for (int j = 0; j < Z; j++) begin
        if (s == 63) p = lane_l(m, j);
        else begin
          src = (j + Z - s) % Z;
          p = clip(model_ext(m, src) + lane_m(st_c2v[k], src), -64, 63);
        end
        eo[j*LW +: LW] = LW'(p);
        eh[j] = (p < 0);
      end
      check(ow ? "R5 R6 R10 out_llr" : "R9 bypass out_llr", out_llr, eo);
      check("R8 out_hard", {252'b0, out_hard}, {252'b0, eh});
    end
  endtask

  task automatic fill_rand(int n);
    for (int i = 0; i < Z; i++) begin
      st_llr[n][i*LW +: LW] = LW'($urandom_range(0, 127));
      st_old[n][i*MW +: MW] = MW'($urandom_range(0, 31));
    end
  endtask

  initial begin
    for (int n = 0; n < NCYC; n++) begin
      fill_rand(n);
      for (int i = 0; i < Z; i++) st_c2v[n][i*MW +: MW] = MW'($urandom_range(0, 31));
      st_val[n] = 1'b1;
      st_sh[n] = SW'($urandom_range(0, Z - 1));
      if (n < 4) st_val[n] = 1'b0;                              // R11 idle
      else if (n < 4 + Z) st_sh[n] = SW'(n - 4);                // R2 sweep, R10 back-to-back
      else if (n < 56) begin if (n % 2 == 0) st_sh[n] = 6'h3f; end // R9
      else if (n < 76) begin                                    // R3 R5 saturation
        for (int i = 0; i < Z; i++) begin
          st_llr[n][i*LW +: LW] = (n % 2 == 0) ? 7'h3f : 7'h40;
          st_old[n][i*MW +: MW] = (n % 2 == 0) ? 5'h10 : 5'h0f;
          st_c2v[n][i*MW +: MW] = (n % 2 == 0) ? 5'h0f : 5'h10;
        end
      end
      else if (n < 100) st_val[n] = (n % 3 != 0);
      else if ($urandom_range(0, 7) == 0) st_sh[n] = 6'h3f;
    end
    // Saturation rows also need their results to meet saturated fresh messages.
    repeat (3) @(negedge clk);
    check("R1 reset v2c_valid", {293'b0, v2c_valid}, '0);
    check("R1 reset out_valid", {293'b0, out_valid}, '0);
    check("R1 reset out_wr_en", {293'b0, out_wr_en}, '0);
    check("R1 reset out_llr", out_llr, '0);
    check("R1 reset out_hard", {252'b0, out_hard}, '0);
    rst_n = 1'b1;
    for (int n = 0; n <= NCYC; n++) begin
      @(negedge clk);
      if (n > 0) check_cycle(n - 1);
      if (n < NCYC) begin
        in_valid   = st_val[n];
        in_shift   = st_sh[n];
        in_llr     = st_llr[n];
        in_old_c2v = st_old[n];
        new_c2v    = st_c2v[n];
      end
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R10 watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule